// File: doc/BRIEF.md
# Buffered-Duty PWM Timer Channel

This block is one pulse-width modulation channel. A 16-bit up-counter runs while the channel is started and sweeps from 1 up to a programmed period value, then starts again at 1. At each period boundary the output is raised. Later in the period it is dropped when the counter reaches the active duty value. The output is therefore high for exactly `duty` clocks out of every `period` clocks.

Software never writes the active duty directly. It writes a staging register instead, and that value moves into the active duty only at a period boundary. A duty change therefore always starts at the beginning of a period. Duty 0 gives a clean 0% output and duty equal to the period gives a clean 100% output. Each period boundary also sets a sticky event flag. That flag, gated by an enable, drives an interrupt request.

All writes use one write port. Address 0 is the period, address 1 is the duty staging register, address 2 is control, and address 3 is unused. In the control word, bit 0 starts the counter, bit 1 enables the interrupt, and bit 2 clears the event flag when written as 1.

Top module: `bufpwm`

## Requirements
- R1: While control bit 0 (run) is 1, the counter increases by one on each clock unless R2 applies. While run is 0, the counter holds its value.
- R2: When run is 1 and the counter equals the period register (address 0), the counter becomes 1 on the next clock. Counting wraps modulo 2^16.
- R3: On a period match, the staging value (address 1) is copied into the active duty. If that value is nonzero, pwm_o is 1 on the next clock.
- R4: When run is 1, there is no period match, the active duty is nonzero and the counter equals it, pwm_o is 0 on the next clock.
- R5: A staging value of 0 gives a pwm_o that stays 0 for every clock of the periods that follow.
- R6: A staging value equal to the period gives a pwm_o that stays 1 continuously, because the set on a period match takes priority over the clear on a duty match.
- R7: A staging write takes effect only from the next period match. In steady state, pwm_o is high for exactly `duty` clocks of every `period` clocks.
- R8: Each period match sets a sticky event flag. irq_o equals the flag ANDed with control bit 1.
- R9: A control write with bit 2 set clears the flag. If a period match occurs in the same clock, the flag stays set. A control write with bit 2 clear leaves the flag unchanged.
- R10: After reset, the counter is 1, pwm_o and irq_o are 0, all registers are 0, and the channel is stopped.
- R11: Writes to address 3 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 period, 1 duty staging, 2 control, 3 unused |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Period interrupt request |
| cnt_o | output | 16 | Current counter value |

## Verification
A write, a period match or a duty match is visible at the outputs one clock after the rising edge that samples it. The staging value reaches the waveform only after the next period match, which can be up to `period` clocks later. The bench drives inputs on the falling edge and advances a reference model by one step for the same inputs. On the next falling edge it compares cnt_o, pwm_o and irq_o, so every result is checked in the exact cycle it is due. Directed phases wait at least two full periods after each staging write and then count the high clocks over one period window.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;
  typedef enum logic [1:0] {
    ADDR_CYC  = 2'd0,
    ADDR_BUF  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  localparam int CTL_RUN = 0;
  localparam int CTL_IE  = 1;
  localparam int CTL_CLR = 2;
  localparam int CTL_BITS = 3;
endpackage

// File: rtl/bufpwm_regs.sv
module bufpwm_regs
  import bufpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cyc_o,
  output logic [W-1:0] buf_o,
  output logic         run_o,
  output logic         ie_o,
  output logic         clr_o
);
  logic wr_cyc, wr_buf, wr_ctl;
  logic unused_bits;

  assign wr_cyc = wr_en_i && (wr_addr_i == ADDR_CYC);
  assign wr_buf = wr_en_i && (wr_addr_i == ADDR_BUF);
  assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_o  = wr_ctl && wr_data_i[CTL_CLR];
  assign unused_bits = ^wr_data_i[W-1:CTL_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o <= '0;
      buf_o <= '0;
      run_o <= 1'b0;
      ie_o  <= 1'b0;
    end else begin
      if (wr_cyc) cyc_o <= wr_data_i;
      if (wr_buf) buf_o <= wr_data_i;
      if (wr_ctl) begin
        run_o <= wr_data_i[CTL_RUN];
        ie_o  <= wr_data_i[CTL_IE];
      end
    end
  end
endmodule

// File: rtl/bufpwm_counter.sv
module bufpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] cyc_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  localparam logic [W-1:0] RELOAD = W'(1);

  assign hit_o = run_i && (cnt_o == cyc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= RELOAD;
    else if (hit_o)    cnt_o <= RELOAD;
    else if (run_i)    cnt_o <= cnt_o + RELOAD;
  end
endmodule

// File: rtl/bufpwm_wave.sv
module bufpwm_wave #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         cyc_hit_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] buf_i,
  input  logic         clr_i,
  output logic [W-1:0] duty_o,
  output logic         pwm_o,
  output logic         flag_o
);
  logic duty_hit;

  // period set outranks duty clear
  assign duty_hit = run_i && !cyc_hit_i && (duty_o != '0) && (cnt_i == duty_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_o <= '0;
      pwm_o  <= 1'b0;
    end else if (cyc_hit_i) begin
      duty_o <= buf_i;
      pwm_o  <= (buf_i != '0);
    end else if (duty_hit) begin
      pwm_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_o <= 1'b0;
    else if (cyc_hit_i) flag_o <= 1'b1;
    else if (clr_i)     flag_o <= 1'b0;
  end
endmodule

// File: rtl/bufpwm.sv
module bufpwm #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic         pwm_o,
  output logic         irq_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cyc_q, buf_q, duty_q;
  logic         run_q, ie_q, clr, cyc_hit, flag_q;

  bufpwm_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cyc_o(cyc_q), .buf_o(buf_q), .run_o(run_q), .ie_o(ie_q), .clr_o(clr)
  );

  bufpwm_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run_q), .cyc_i(cyc_q), .cnt_o(cnt_o), .hit_o(cyc_hit)
  );

  bufpwm_wave #(.W(W)) u_wave (
    .clk_i, .rst_ni, .run_i(run_q), .cyc_hit_i(cyc_hit), .cnt_i(cnt_o),
    .buf_i(buf_q), .clr_i(clr), .duty_o(duty_q), .pwm_o(pwm_o), .flag_o(flag_q)
  );

  assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/bufpwm_chk.sv
module bufpwm_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         ie_i,
  input logic [W-1:0] cyc_i,
  input logic [W-1:0] buf_i,
  input logic [W-1:0] duty_i,
  input logic         flag_i,
  input logic         pwm_i,
  input logic         irq_i,
  input logic [W-1:0] cnt_i
);
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i != cyc_i) |=> (cnt_i == W'($past(cnt_i) + W'(1)))); // R1
  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cyc_i) |=> (cnt_i == W'(1))); // R2
  AST_PWM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cyc_i && buf_i != '0) |=> pwm_i); // R3
  AST_PWM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i != cyc_i && duty_i != '0 && cnt_i == duty_i) |=> !pwm_i); // R4
  AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cyc_i && buf_i == '0) |=> !pwm_i); // R5
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cyc_i) |=> flag_i); // R8
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ie_i && flag_i)); // R8
endmodule

bind bufpwm bufpwm_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .ie_i(ie_q), .cyc_i(cyc_q),
  .buf_i(buf_q), .duty_i(duty_q), .flag_i(flag_q), .pwm_i(pwm_o),
  .irq_i(irq_o), .cnt_i(cnt_o)
);

// File: tb/bufpwm_tb.sv
module bufpwm_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         pwm, irq;
  logic [W-1:0] cnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_cnt = 16'd1, m_cyc = '0, m_buf = '0, m_duty = '0;
  logic m_pwm = 0, m_flag = 0, m_run = 0, m_ie = 0;

  always #10 clk = ~clk;

  bufpwm #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .irq_o(irq), .cnt_o(cnt)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic we, input logic [1:0] a, input logic [W-1:0] d);
    logic hit, dhit;
    hit  = m_run && (m_cnt == m_cyc);
    dhit = m_run && !hit && (m_duty != '0) && (m_cnt == m_duty);
    if (hit) begin
      m_cnt = 16'd1; m_pwm = (m_buf != '0); m_duty = m_buf; m_flag = 1'b1;
    end else begin
      if (m_run) m_cnt = m_cnt + 16'd1;
      if (dhit) m_pwm = 1'b0;
      if (we && a == 2'd2 && d[2]) m_flag = 1'b0;
    end
    if (we) begin
      case (a)
        2'd0: m_cyc = d;
        2'd1: m_buf = d;
        2'd2: begin m_run = d[0]; m_ie = d[1]; end
        default: ;
      endcase
    end
  endtask

  // compare at falling edge, then drive and advance model
  task automatic cycle(input logic we, input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    check("R1 R2 cnt", cnt, m_cnt);
    check("R3 R4 R5 R6 R7 pwm", {15'd0, pwm}, {15'd0, m_pwm});
    check("R8 R9 irq", {15'd0, irq}, {15'd0, m_flag & m_ie});
    wr_en = we; wr_addr = a; wr_data = d;
    model_step(we, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, '0);
  endtask

  task automatic high_count(input string tag, input int per, input int exp);
    int hi = 0;
    for (int i = 0; i < per; i++) begin
      cycle(1'b0, 2'd0, '0);
      hi += int'(pwm);
    end
    check(tag, W'(hi), W'(exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    #35 rst_n = 1'b1;
    @(negedge clk);
    check("R10 cnt", cnt, 16'd1);
    check("R10 pwm", {15'd0, pwm}, 16'd0);
    check("R10 irq", {15'd0, irq}, 16'd0);
    idle(3);
    check("R1 stopped", cnt, 16'd1);

    // directed: period 5
    cycle(1'b1, 2'd0, 16'd5);
    cycle(1'b1, 2'd1, 16'd2);
    cycle(1'b1, 2'd2, 16'h3);
    idle(12);
    high_count("R7 duty2", 5, 2);
    cycle(1'b1, 2'd1, 16'd0);
    idle(11);
    high_count("R5 zero", 5, 0);
    cycle(1'b1, 2'd1, 16'd5);
    idle(11);
    high_count("R6 full", 5, 5);
    cycle(1'b1, 2'd3, 16'hFFFF);
    idle(6);
    check("R11 rsvd irq", {15'd0, irq}, 16'd1);
    cycle(1'b1, 2'd2, 16'h7);
    idle(1);
    cycle(1'b1, 2'd2, 16'h2);
    idle(8);

    // random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3)       cycle(1'b1, 2'd0, W'($urandom_range(1, 12)));
      else if (r < 12) begin
        int s = $urandom_range(0, 3);
        logic [W-1:0] v = (s == 0) ? '0 : (s == 1) ? m_cyc : W'($urandom_range(0, int'(m_cyc)));
        cycle(1'b1, 2'd1, v);
      end
      else if (r < 16) cycle(1'b1, 2'd2, W'($urandom_range(0, 7)) | ((r < 15) ? 16'd1 : 16'd0));
      else if (r < 18) cycle(1'b1, 2'd3, W'($urandom));
      else             cycle(1'b0, 2'd0, '0);
    end
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule